// File: doc/BRIEF.md
# Fractional Hold Register

This block is a one-slot synchronous element placed directly in front of a computation node. Each cycle it sees a token strobe with a data word, and a hold control driven by a static schedule computed elsewhere. When hold is high, the element keeps a token in its single slot for one more cycle. Tokens that arrive early on a fast arc can be delayed this way by a fraction of the average token spacing. They then reach the node in the same cycle as tokens on the slower arcs. No flow-control handshake is involved.

The slot is filled in exactly the cycles after hold was high. A held token can be kept for several cycles in a row. It can also be swapped out: it leaves in the same cycle that a new token enters. Two input combinations are illegal under a consistent schedule: holding when there is nothing to hold, and letting a token arrive at an occupied slot without hold. Either one sets a sticky error flag and leaves the slot unchanged.

Top module: `frac_hold_reg`

## Requirements
- R1: After reset the slot is empty (`occupied_o`=0), the error flag is low, and no token is output while no token arrives.
- R2: With the slot empty, a token arriving with hold low leaves in the same cycle: `tok_valid_o`=1 and `tok_data_o` equals `tok_data_i`. The slot stays empty.
- R3: With the slot empty, a token arriving with hold high produces no output in that cycle. From the next cycle the slot is occupied and holds that token's data.
- R4: With the slot occupied, hold low and no arriving token, the held data is output in the same cycle and the slot is empty from the next cycle.
- R5: With the slot occupied, hold high and no arriving token, nothing is output and the same data stays held. This can repeat for any number of cycles.
- R6: With the slot occupied, hold high and a token arriving, the held data is output in the same cycle and the arriving data is held from the next cycle.
- R7: Hold high with no arriving token and an empty slot is illegal. The error flag is set from the next cycle, nothing is output and the slot stays empty.
- R8: A token arriving at an occupied slot with hold low is illegal. The error flag is set from the next cycle. The arriving token is passed out in the same cycle and the held token stays in the slot.
- R9: Once set, the error flag stays high until reset, whatever the later inputs are.
- R10: `occupied_o` equals the value of hold in the previous cycle whenever that cycle was legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tok_valid_i | input | 1 | A token arrives this cycle |
| tok_data_i | input | DATA_W | Data carried by the arriving token |
| hold_i | input | 1 | Scheduled hold for this cycle |
| tok_valid_o | output | 1 | A token leaves toward the node this cycle |
| tok_data_o | output | DATA_W | Data of the leaving token |
| occupied_o | output | 1 | The slot holds a token |
| hold_err_o | output | 1 | Sticky flag: an illegal input combination was seen |

## Verification
The design is first driven with directed sequences for pass-through, single-cycle capture and release, a hold kept over several cycles, and a burst of back-to-back swaps. These separate the three output cases from the idle cases, and show whether a swap emits the old word or the new one. A long pseudo-random legal schedule then mixes every legal transition. The data word changes every cycle, so any mix-up between the held and the incoming data shows up. Finally, both illegal combinations are applied, one on each side of a reset. This shows that the flag is sticky, that reset clears it, and that the slot contents survive an illegal cycle.

// File: rtl/frh_pkg.sv
package frh_pkg;
  typedef enum logic [2:0] {
    SIT_IDLE,
    SIT_PASS,
    SIT_CAPTURE,
    SIT_RELEASE,
    SIT_KEEP,
    SIT_SWAP,
    SIT_ERR_EMPTY,
    SIT_ERR_COLLIDE
  } sit_e;
endpackage

// File: rtl/frh_classify.sv
module frh_classify
  import frh_pkg::*;
(
  input  logic tok_i,
  input  logic occ_i,
  input  logic hold_i,
  output sit_e sit_o,
  output logic illegal_o
);
  always_comb begin
    unique case ({tok_i, occ_i, hold_i})
      3'b000:  sit_o = SIT_IDLE;
      3'b001:  sit_o = SIT_ERR_EMPTY;
      3'b100:  sit_o = SIT_PASS;
      3'b101:  sit_o = SIT_CAPTURE;
      3'b010:  sit_o = SIT_RELEASE;
      3'b011:  sit_o = SIT_KEEP;
      3'b110:  sit_o = SIT_ERR_COLLIDE;
      default: sit_o = SIT_SWAP;
    endcase
  end

  assign illegal_o = (sit_o == SIT_ERR_EMPTY) || (sit_o == SIT_ERR_COLLIDE);
endmodule

// File: rtl/frh_slot.sv
module frh_slot
  import frh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sit_e              sit_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              occ_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic              occ_q, occ_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              err_q;
  logic              bad;

  assign bad = (sit_i == SIT_ERR_EMPTY) || (sit_i == SIT_ERR_COLLIDE);

  always_comb begin
    occ_d  = occ_q;
    data_d = data_q;
    unique case (sit_i)
      SIT_CAPTURE, SIT_SWAP: begin
        occ_d  = 1'b1;
        data_d = data_i;
      end
      SIT_RELEASE: occ_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= 1'b0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      occ_q  <= occ_d;
      data_q <= data_d;
      if (bad) err_q <= 1'b1;
    end
  end

  assign occ_o  = occ_q;
  assign data_o = data_q;
  assign err_o  = err_q;

  AST_SLOT_FOLLOWS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad |=> occ_q == $past(hold_i)); // R10
  AST_ILLEGAL_KEEPS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> $stable(occ_q) && $stable(data_q)); // R8
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> err_q); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R9
  AST_KEEP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sit_i == SIT_KEEP |=> occ_q && $stable(data_q)); // R5
endmodule

// File: rtl/frh_out_mux.sv
module frh_out_mux
  import frh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  sit_e              sit_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [DATA_W-1:0] held_data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic from_slot;

  always_comb begin
    valid_o   = 1'b0;
    from_slot = 1'b0;
    unique case (sit_i)
      SIT_PASS, SIT_ERR_COLLIDE: valid_o = 1'b1;
      SIT_RELEASE, SIT_SWAP: begin
        valid_o   = 1'b1;
        from_slot = 1'b1;
      end
      default: ;
    endcase
  end

  assign data_o = from_slot ? held_data_i : in_data_i;
endmodule

// File: rtl/frac_hold_reg.sv
module frac_hold_reg
  import frh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_valid_i,
  input  logic [DATA_W-1:0] tok_data_i,
  input  logic              hold_i,
  output logic              tok_valid_o,
  output logic [DATA_W-1:0] tok_data_o,
  output logic              occupied_o,
  output logic              hold_err_o
);
  sit_e              sit;
  logic              illegal;
  logic              occ;
  logic [DATA_W-1:0] held;

  frh_classify u_classify (
    .tok_i     (tok_valid_i),
    .occ_i     (occ),
    .hold_i    (hold_i),
    .sit_o     (sit),
    .illegal_o (illegal)
  );

  frh_slot #(.DATA_W(DATA_W)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sit_i  (sit),
    .hold_i (hold_i),
    .data_i (tok_data_i),
    .occ_o  (occ),
    .data_o (held),
    .err_o  (hold_err_o)
  );

  frh_out_mux #(.DATA_W(DATA_W)) u_mux (
    .sit_i       (sit),
    .in_data_i   (tok_data_i),
    .held_data_i (held),
    .valid_o     (tok_valid_o),
    .data_o      (tok_data_o)
  );

  assign occupied_o = occ;

  AST_EMPTY_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i && !occupied_o |-> !tok_valid_o); // R1
  AST_SWAP_OLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && occupied_o && hold_i |-> tok_valid_o && tok_data_o == held); // R6
  AST_CAPTURE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && !occupied_o && hold_i |-> !tok_valid_o); // R3
  AST_CAPTURE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && hold_i |=> occupied_o && held == $past(tok_data_i)); // R3
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i && occupied_o && !hold_i |=> !occupied_o); // R4
  AST_ILLEGAL_IS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |=> hold_err_o); // R7
endmodule

// File: tb/frac_hold_reg_tb.sv
module frac_hold_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tok_valid_i = 1'b0;
  logic [DATA_W-1:0] tok_data_i = '0;
  logic              hold_i = 1'b0;
  logic              tok_valid_o;
  logic [DATA_W-1:0] tok_data_o;
  logic              occupied_o;
  logic              hold_err_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model
  bit              m_err;
  logic [DATA_W-1:0] m_slot[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_hold_reg #(.DATA_W(DATA_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tok_valid_i (tok_valid_i),
    .tok_data_i  (tok_data_i),
    .hold_i      (hold_i),
    .tok_valid_o (tok_valid_o),
    .tok_data_o  (tok_data_o),
    .occupied_o  (occupied_o),
    .hold_err_o  (hold_err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, compare before next posedge, update model at posedge
  task automatic step(input bit t, input bit h, input logic [DATA_W-1:0] d);
    bit occ;
    bit exp_v;
    int exp_d;
    string req;
    @(negedge clk);
    tok_valid_i = t;
    hold_i      = h;
    tok_data_i  = d;
    #1;
    occ   = (m_slot.size() != 0);
    exp_v = 0;
    exp_d = 0;
    if (!t && !occ && !h)      req = "R1";
    else if (!t && !occ && h)  req = "R7";
    else if (t && !occ && !h) begin req = "R2"; exp_v = 1; exp_d = d; end
    else if (t && !occ && h)   req = "R3";
    else if (!t && occ && !h) begin req = "R4"; exp_v = 1; exp_d = m_slot[0]; end
    else if (!t && occ && h)   req = "R5";
    else if (t && occ && !h) begin req = "R8"; exp_v = 1; exp_d = d; end
    else begin req = "R6"; exp_v = 1; exp_d = m_slot[0]; end
    chk("R10", "occupied", occupied_o, occ);
    chk("R9", "error flag", hold_err_o, m_err);
    chk(req, "valid out", tok_valid_o, exp_v);
    if (exp_v) chk(req, "data out", tok_data_o, exp_d);
    @(posedge clk);
    case (req)
      "R7", "R8": m_err = 1;
      "R3": m_slot.push_back(d);
      "R4": void'(m_slot.pop_front());
      "R6": begin void'(m_slot.pop_front()); m_slot.push_back(d); end
      default: ;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    tok_valid_i = 0;
    hold_i = 0;
    m_err = 0;
    m_slot.delete();
    #1;
    chk("R1", "reset occupied", occupied_o, 0);
    chk("R1", "reset error", hold_err_o, 0);
    chk("R1", "reset valid out", tok_valid_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit t, h, occ;
    do_reset();
    step(0, 0, 8'h00);                 // R1 idle
    step(1, 0, 8'h11);                 // R2 pass
    step(1, 0, 8'h12);                 // R2 pass
    step(1, 1, 8'h21);                 // R3 capture
    step(0, 0, 8'h00);                 // R4 release
    step(1, 1, 8'h31);                 // R3
    for (int i = 0; i < 4; i++) step(0, 1, 8'hEE); // R5 long hold
    step(0, 0, 8'h00);                 // R4
    step(1, 1, 8'h41);                 // R3
    for (int i = 0; i < 5; i++) step(1, 1, 8'h50 + 8'(i)); // R6 burst swap
    step(0, 0, 8'h00);                 // R4
    // pseudo-random legal schedule
    for (int i = 0; i < 400; i++) begin
      occ = (m_slot.size() != 0);
      t = $urandom_range(0, 1);
      h = $urandom_range(0, 1);
      if (!occ && !t) h = 0;
      if (occ && t) h = 1;
      step(t, h, 8'($urandom));
    end
    if (m_slot.size() != 0) step(0, 0, 8'h00);
    // illegal: hold with nothing
    step(0, 1, 8'h77);                 // R7
    for (int i = 0; i < 3; i++) step(1, 0, 8'h60 + 8'(i)); // R9 flag stays
    step(1, 1, 8'h81);
    step(0, 0, 8'h00);
    do_reset();
    step(0, 0, 8'h00);                 // R1 flag cleared
    step(1, 1, 8'h91);                 // R3
    step(1, 0, 8'h92);                 // R8 collide, held 91 kept
    step(0, 1, 8'h00);                 // R5
    step(0, 0, 8'h00);                 // R4 releases 91
    step(0, 0, 8'h00);
    finish_run();
  end
endmodule